// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block holds a one-time-programmable bit array built from 32-bit rows. The array is divided into a fixed number of equal banks. A program port takes one bit index per request and can only turn that bit on. Requests that name a guarded index, or an index beyond the array, are refused and leave the array untouched. A row read port returns any 32-bit row one cycle after it is asked for.

A bank-signature check walks the banks one per cycle. It inspects a 4-bit marker field at the top of each bank's first row and returns a pass vector with one bit per bank. When the caller enables repair, a marker field that is still entirely blank is stamped with the signature before it is judged. A marker that holds any other non-zero value is reported as failing and left as it is. The set of guarded indices is fixed by parameters. Only the first `PROT_CNT` table slots take part in the comparison.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: Bit index `i` maps to row `i / 32`, bit position `i % 32` of that row, as seen on the row read port.
- R2: A program request only sets its bit. Bits already at one stay at one, and nothing clears a bit. Re-programming a set bit reports ok.
- R3: A request whose index equals one of the first `PROT_CNT` entries of the guarded table is refused (`prg_ok` = 0) and the array does not change.
- R4: Guarded-table slots at positions `PROT_CNT` and above have no effect: their indices program normally.
- R5: An index at or above `NUM_BANKS*BANK_BITS` is refused (`prg_ok` = 0) and the array does not change.
- R6: `prg_done` pulses in the cycle after `prg_valid` is sampled, with `prg_ok` valid alongside it. The updated row is visible to a read sampled in that same following cycle.
- R7: `rd_rvalid` and `rd_data` follow one cycle after `rd_valid` is sampled. A row number beyond the array reads as zero.
- R8: Reset (synchronous, active high) clears every row to zero and drops `prg_done`, `rd_rvalid`, `chk_busy` and `chk_done`.
- R9: The marker of bank `b` is bits 31:28 of row `b*BANK_BITS/32`. A bank passes when that field equals 4'b1010. Bit `b` of `chk_pass` belongs to bank `b`.
- R10: With `chk_autoinit` = 1, a marker field of 4'b0000 is written to 4'b1010, and that bank passes. With `chk_autoinit` = 0, a blank marker fails and stays blank.
- R11: A non-zero marker other than 4'b1010 fails and is never rewritten.
- R12: `chk_busy` rises in the cycle after `chk_start` is sampled while idle. `chk_done` is a one-cycle pulse `NUM_BANKS+1` cycles after the start is sampled, and it clears `chk_busy`. A start sampled while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prg_valid | input | 1 | Program request strobe |
| prg_idx | input | IDX_W | Bit index to program |
| prg_done | output | 1 | Program request completed |
| prg_ok | output | 1 | Program request accepted |
| rd_valid | input | 1 | Row read request strobe |
| rd_row | input | ROW_AW | Row number to read |
| rd_rvalid | output | 1 | Read data valid |
| rd_data | output | 32 | Row contents |
| chk_start | input | 1 | Start a bank-signature check |
| chk_autoinit | input | 1 | Stamp blank markers during the check |
| chk_busy | output | 1 | Check in progress |
| chk_done | output | 1 | Check result valid (one cycle) |
| chk_pass | output | NUM_BANKS | Per-bank pass vector, bank 0 in bit 0 |

## Verification
Some properties are checked on every cycle. A sampled program request is always answered in the next cycle. An out-of-range index is never accepted. A row read twice in a row never loses a bit. The check's busy and done strobes follow their handshake. Other behaviour needs scenarios the bench builds: which indices are guarded, the bank order inside the pass vector, repair of blank markers versus refusal of damaged ones, and the exact row and bit a given index lands on. The bench covers these with a full sweep over every index of a small three-bank array, checked against an arithmetic model.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int ROW_W   = 32;
    localparam int ROW_SH  = 5;
    localparam int MARK_LO = 28;
    localparam int MARK_W  = 4;
    localparam logic [MARK_W-1:0] MARK_SIG = 4'b1010;

    typedef enum logic {
        SC_IDLE,
        SC_RUN
    } scan_st_e;

    typedef struct packed {
        logic pass;
        logic fix;
    } mark_res_t;

    typedef struct packed {
        logic done;
        logic ok;
    } prg_rsp_t;

    function automatic mark_res_t mark_eval(logic [MARK_W-1:0] field, logic autoinit);
        mark_res_t r;
        r.fix  = (field == '0) && autoinit;
        r.pass = r.fix || (field == MARK_SIG);
        return r;
    endfunction

    function automatic logic [ROW_W-1:0] mark_word();
        return ROW_W'(MARK_SIG) << MARK_LO;
    endfunction

endpackage

// File: rtl/otp_guard_match.sv
module otp_guard_match #(
    parameter int IDX_W    = 13,
    parameter int PROT_MAX = 8,
    parameter int PROT_CNT = 0,
    parameter logic [PROT_MAX*IDX_W-1:0] PROT_LIST = '0
) (
    input  logic [IDX_W-1:0] idx,
    output logic             hit
);
    logic [PROT_MAX-1:0] slot_hit;

    for (genvar s = 0; s < PROT_MAX; s++) begin : g_slot
        localparam logic [IDX_W-1:0] ENTRY = PROT_LIST[s*IDX_W +: IDX_W];
        if (s < PROT_CNT) begin : g_live
            assign slot_hit[s] = (idx == ENTRY);
        end else begin : g_idle
            assign slot_hit[s] = 1'b0;
        end
    end

    assign hit = |slot_hit;
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
    parameter int ROWS   = 192,
    parameter int ROW_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prg_we,
    input  logic [ROW_AW-1:0] prg_row,
    input  logic [4:0]        prg_bit,
    input  logic              fix_we,
    input  logic [ROW_AW-1:0] fix_row,
    input  logic [ROW_AW-1:0] rd_addr,
    output logic [31:0]       rd_word,
    input  logic [ROW_AW-1:0] sc_addr,
    output logic [31:0]       sc_word
);
    import otp_pkg::*;

    logic [ROWS-1:0][ROW_W-1:0] rows_w;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [ROW_W-1:0] q;
        logic [ROW_W-1:0] add;

        always_comb begin
            add = '0;
            if (prg_we && (prg_row == ROW_AW'(r)))
                add = add | (ROW_W'(1) << prg_bit);
            if (fix_we && (fix_row == ROW_AW'(r)))
                add = add | mark_word();
        end

        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else
                q <= q | add;
        end

        assign rows_w[r] = q;
    end

    always_comb begin
        rd_word = '0;
        if (32'(rd_addr) < ROWS)
            rd_word = rows_w[rd_addr];
    end

    always_comb begin
        sc_word = '0;
        if (32'(sc_addr) < ROWS)
            sc_word = rows_w[sc_addr];
    end
endmodule

// File: rtl/otp_mark_scan.sv
module otp_mark_scan #(
    parameter int NUM_BANKS     = 3,
    parameter int ROWS_PER_BANK = 64,
    parameter int ROW_AW        = 8,
    parameter int BANK_W        = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 autoinit,
    output logic [ROW_AW-1:0]    sc_addr,
    input  logic [31:0]          sc_word,
    output logic                 fix_we,
    output logic [ROW_AW-1:0]    fix_row,
    output logic                 busy,
    output logic                 done,
    output logic [NUM_BANKS-1:0] pass
);
    import otp_pkg::*;

    scan_st_e             st_q;
    logic [BANK_W-1:0]    bank_q;
    logic                 ai_q;
    logic [NUM_BANKS-1:0] acc_q;
    logic [NUM_BANKS-1:0] acc_n;
    mark_res_t            res;

    assign sc_addr = ROW_AW'(32'(bank_q) * ROWS_PER_BANK);
    assign res     = mark_eval(sc_word[MARK_LO +: MARK_W], ai_q);
    assign fix_we  = (st_q == SC_RUN) && res.fix;
    assign fix_row = sc_addr;
    assign acc_n   = (acc_q << 1) | NUM_BANKS'(res.pass);
    assign busy    = (st_q == SC_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SC_IDLE;
            bank_q <= '0;
            ai_q   <= 1'b0;
            acc_q  <= '0;
            done   <= 1'b0;
            pass   <= '0;
        end else begin
            done <= 1'b0;
            case (st_q)
                SC_IDLE: begin
                    if (start) begin
                        st_q   <= SC_RUN;
                        bank_q <= BANK_W'(NUM_BANKS - 1);
                        ai_q   <= autoinit;
                        acc_q  <= '0;
                    end
                end
                SC_RUN: begin
                    acc_q <= acc_n;
                    if (bank_q == '0) begin
                        st_q <= SC_IDLE;
                        done <= 1'b1;
                        pass <= acc_n;
                    end else begin
                        bank_q <= bank_q - 1'b1;
                    end
                end
                default: st_q <= SC_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl #(
    parameter  int NUM_BANKS = 3,
    parameter  int BANK_BITS = 2048,
    parameter  int PROT_MAX  = 8,
    localparam int ROWS_PER_BANK = BANK_BITS / 32,
    localparam int ROWS      = NUM_BANKS * ROWS_PER_BANK,
    localparam int IDX_W     = $clog2(ROWS * 32),
    localparam int ROW_AW    = (ROWS > 1) ? $clog2(ROWS) : 1,
    parameter  int PROT_CNT  = 0,
    parameter  logic [PROT_MAX*IDX_W-1:0] PROT_LIST = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 prg_valid,
    input  logic [IDX_W-1:0]     prg_idx,
    output logic                 prg_done,
    output logic                 prg_ok,
    input  logic                 rd_valid,
    input  logic [ROW_AW-1:0]    rd_row,
    output logic                 rd_rvalid,
    output logic [31:0]          rd_data,
    input  logic                 chk_start,
    input  logic                 chk_autoinit,
    output logic                 chk_busy,
    output logic                 chk_done,
    output logic [NUM_BANKS-1:0] chk_pass
);
    import otp_pkg::*;

    localparam int TOTAL_BITS = ROWS * 32;
    localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic              guard_hit;
    logic              in_range;
    logic              accept;
    logic              fix_we;
    logic [ROW_AW-1:0] fix_row;
    logic [ROW_AW-1:0] sc_addr;
    logic [31:0]       sc_word;
    logic [31:0]       rd_word;
    prg_rsp_t          rsp_q;

    otp_guard_match #(
        .IDX_W    (IDX_W),
        .PROT_MAX (PROT_MAX),
        .PROT_CNT (PROT_CNT),
        .PROT_LIST(PROT_LIST)
    ) u_guard (
        .idx(prg_idx),
        .hit(guard_hit)
    );

    assign in_range = 32'(prg_idx) < TOTAL_BITS;
    assign accept   = prg_valid && in_range && !guard_hit;

    otp_fuse_array #(
        .ROWS  (ROWS),
        .ROW_AW(ROW_AW)
    ) u_array (
        .clk    (clk),
        .rst    (rst),
        .prg_we (accept),
        .prg_row(ROW_AW'(prg_idx >> ROW_SH)),
        .prg_bit(prg_idx[4:0]),
        .fix_we (fix_we),
        .fix_row(fix_row),
        .rd_addr(rd_row),
        .rd_word(rd_word),
        .sc_addr(sc_addr),
        .sc_word(sc_word)
    );

    otp_mark_scan #(
        .NUM_BANKS    (NUM_BANKS),
        .ROWS_PER_BANK(ROWS_PER_BANK),
        .ROW_AW       (ROW_AW),
        .BANK_W       (BANK_W)
    ) u_scan (
        .clk     (clk),
        .rst     (rst),
        .start   (chk_start),
        .autoinit(chk_autoinit),
        .sc_addr (sc_addr),
        .sc_word (sc_word),
        .fix_we  (fix_we),
        .fix_row (fix_row),
        .busy    (chk_busy),
        .done    (chk_done),
        .pass    (chk_pass)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q     <= '0;
            rd_rvalid <= 1'b0;
            rd_data   <= '0;
        end else begin
            rsp_q.done <= prg_valid;
            rsp_q.ok   <= accept;
            rd_rvalid  <= rd_valid;
            if (rd_valid)
                rd_data <= rd_word;
        end
    end

    assign prg_done = rsp_q.done;
    assign prg_ok   = rsp_q.ok;
endmodule

// File: rtl/otp_fuse_chk.sv
module otp_fuse_chk #(
    parameter int NUM_BANKS  = 3,
    parameter int IDX_W      = 13,
    parameter int ROW_AW     = 8,
    parameter int TOTAL_BITS = 6144
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 prg_valid,
    input logic [IDX_W-1:0]     prg_idx,
    input logic                 prg_done,
    input logic                 prg_ok,
    input logic                 rd_rvalid,
    input logic [ROW_AW-1:0]    rd_row,
    input logic [31:0]          rd_data,
    input logic                 chk_start,
    input logic                 chk_busy,
    input logic                 chk_done
);
    // R6
    prg_answer_chk: assert property (@(posedge clk) disable iff (rst)
        prg_valid |=> prg_done);

    // R6
    ok_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        prg_ok |-> prg_done);

    // R5
    range_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (prg_valid && (32'(prg_idx) >= TOTAL_BITS)) |=> (prg_done && !prg_ok));

    // R2
    no_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_rvalid && $past(rd_rvalid) && ($past(rd_row, 1) == $past(rd_row, 2)))
        |-> ((rd_data & $past(rd_data)) == $past(rd_data)));

    // R12
    busy_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_start && !chk_busy) |=> chk_busy);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        chk_done |=> !chk_done);

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        chk_done |-> (!chk_busy && $past(chk_busy)));
endmodule

bind otp_fuse_ctrl otp_fuse_chk #(
    .NUM_BANKS (NUM_BANKS),
    .IDX_W     (IDX_W),
    .ROW_AW    (ROW_AW),
    .TOTAL_BITS(TOTAL_BITS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .prg_valid(prg_valid),
    .prg_idx  (prg_idx),
    .prg_done (prg_done),
    .prg_ok   (prg_ok),
    .rd_rvalid(rd_rvalid),
    .rd_row   (rd_row),
    .rd_data  (rd_data),
    .chk_start(chk_start),
    .chk_busy (chk_busy),
    .chk_done (chk_done)
);

// File: tb/tb_otp_fuse_ctrl.sv
module tb_otp_fuse_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NB    = 3;
    localparam int BBITS = 64;
    localparam int RPB   = BBITS / 32;
    localparam int NROWS = NB * RPB;
    localparam int TOTAL = NROWS * 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prg_valid = 1'b0;
    logic [7:0] prg_idx = '0;
    logic       prg_done, prg_ok;
    logic       rd_valid = 1'b0;
    logic [2:0] rd_row = '0;
    logic       rd_rvalid;
    logic [31:0] rd_data;
    logic       chk_start = 1'b0;
    logic       chk_autoinit = 1'b0;
    logic       chk_busy, chk_done;
    logic [NB-1:0] chk_pass;

    int nvec = 0;
    int nfail = 0;
    logic [31:0] model [NROWS];

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_fuse_ctrl #(
        .NUM_BANKS(NB),
        .BANK_BITS(BBITS),
        .PROT_MAX (4),
        .PROT_CNT (3),
        .PROT_LIST({8'd7, 8'd100, 8'd40, 8'd5})
    ) dut (
        .clk(clk), .rst(rst),
        .prg_valid(prg_valid), .prg_idx(prg_idx),
        .prg_done(prg_done), .prg_ok(prg_ok),
        .rd_valid(rd_valid), .rd_row(rd_row),
        .rd_rvalid(rd_rvalid), .rd_data(rd_data),
        .chk_start(chk_start), .chk_autoinit(chk_autoinit),
        .chk_busy(chk_busy), .chk_done(chk_done), .chk_pass(chk_pass)
    );

    function automatic bit guarded(int idx);
        return (idx == 5) || (idx == 40) || (idx == 100);
    endfunction

    task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    task automatic do_read(int row, string req);
        logic [31:0] exp;
        exp = (row < NROWS) ? model[row] : 32'h0;
        @(negedge clk);
        rd_valid = 1'b1;
        rd_row   = row[2:0];
        @(negedge clk);
        rd_valid = 1'b0;
        check_eq("R7 rvalid", 32'(rd_rvalid), 32'd1);
        check_eq(req, rd_data, exp);
    endtask

    task automatic do_prog(int idx);
        bit    exp_ok;
        string tag;
        exp_ok = (idx < TOTAL) && !guarded(idx);
        tag = (idx >= TOTAL) ? "R5 ok" : (guarded(idx) ? "R3 ok" : "R2 ok");
        @(negedge clk);
        prg_valid = 1'b1;
        prg_idx   = idx[7:0];
        @(negedge clk);
        prg_valid = 1'b0;
        check_eq("R6 done", 32'(prg_done), 32'd1);
        check_eq(tag, 32'(prg_ok), 32'(exp_ok));
        if (exp_ok)
            model[idx / 32][idx % 32] = 1'b1;
        if (idx < TOTAL)
            do_read(idx / 32, "R1 row after program");
    endtask

    task automatic do_check(bit ai, bit poke);
        logic [NB-1:0] exp;
        for (int b = NB - 1; b >= 0; b--) begin
            logic [3:0] f;
            f = model[b * RPB][31:28];
            if (f == 4'h0 && ai) begin
                model[b * RPB][31:28] = 4'hA;
                exp[b] = 1'b1;
            end else begin
                exp[b] = (f == 4'hA);
            end
        end
        @(negedge clk);
        chk_start    = 1'b1;
        chk_autoinit = ai;
        @(negedge clk);
        chk_start = poke;
        check_eq("R12 busy", 32'(chk_busy), 32'd1);
        for (int k = 1; k <= NB; k++) begin
            @(negedge clk);
            chk_start = 1'b0;
            check_eq("R12 done timing", 32'(chk_done), 32'(k == NB));
        end
        check_eq("R9 pass vector", 32'(chk_pass), 32'(exp));
        check_eq("R12 idle at done", 32'(chk_busy), 32'd0);
        @(negedge clk);
        check_eq("R12 single done", 32'(chk_done), 32'd0);
        check_eq("R12 start while busy ignored", 32'(chk_busy), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog R12 actual=timeout expected=finish");
        report();
    end

    initial begin
        for (int r = 0; r < NROWS; r++) model[r] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R8 prg_done", 32'(prg_done), 32'd0);
        check_eq("R8 rd_rvalid", 32'(rd_rvalid), 32'd0);
        check_eq("R8 chk_busy", 32'(chk_busy), 32'd0);
        check_eq("R8 chk_done", 32'(chk_done), 32'd0);
        rst = 1'b0;
        for (int r = 0; r < 8; r++) do_read(r, (r < NROWS) ? "R8 cleared row" : "R7 out of range row");

        // R10: no repair without autoinit, blank markers fail and stay blank
        do_check(1'b0, 1'b0);
        for (int b = 0; b < NB; b++) do_read(b * RPB, "R10 blank kept");

        // R9: only bank 1 carries the signature
        do_prog(64 + 29);
        do_prog(64 + 31);
        do_check(1'b0, 1'b1);

        // R11: damaged marker on bank 2
        do_prog(128 + 28);
        do_prog(128 + 29);
        do_check(1'b1, 1'b1);
        do_read(0, "R10 repaired marker");
        do_read(2 * RPB, "R11 damaged marker kept");

        // R4: slot beyond the live count
        do_prog(7);

        // R1 R2 R3 R5: full sweeps, second one re-programs set bits
        for (int i = 0; i < 256; i++) do_prog(i);
        for (int i = 255; i >= 0; i--) do_prog(i);
        for (int r = 0; r < NROWS; r++) do_read(r, "R3 final row");
        check_eq("R3 guarded bits clear", {29'd0, model[0][5], model[1][8], model[3][4]}, 32'd0);

        do_check(1'b1, 1'b0);
        report();
    end
endmodule